// File: doc/BRIEF.md
# Bit-Serial CRC-5 Remainder Checker

This block checks a serial codeword against a fixed degree-5 generator, x^5 + x^4 + x^2 + 1 (binary 110101). One message bit enters per clock cycle, most significant bit first, and only in cycles where the valid strobe is high. A 5-bit shift register holds the running remainder of the modulo-2 long division. Modulo-2 arithmetic has no carry and no borrow, so each subtraction of the generator is a plain XOR.

The sender appends the check bits to the message. Once the whole codeword, check bits included, has been shifted in, the remainder is all zeros if the codeword arrived intact. A combinational flag reports a zero remainder. A synchronous clear starts a new codeword.

The register width and the generator are parameters. The default values implement the degree-5 code.

Top module: `serial_crc_checker`

## Requirements
- R1: When `clear` is high at a rising clock edge, the remainder becomes 00000.
- R2: On each valid bit, the remainder shifts left by one and the new bit enters at bit 0. If the bit shifted out of bit 4 was 1, the result is also XORed with 10101.
- R3: Starting from 00000, the valid bits 1,0,1,0,0 give the remainders 00001, 00010, 00101, 01010 and 10100, one per bit. A further 0 bit then gives 11101.
- R4: Shifting in the 15-bit codeword 101000110101110, MSB first, leaves the remainder 00000.
- R5: While the remainder is 00000, a valid 0 bit keeps it at 00000.
- R6: In a cycle where `bit_valid` is low, the remainder does not change, whatever `bit_in` is.
- R7: `rem_zero` is high exactly when `remainder` equals 00000, in the same cycle, with no register delay.
- R8: `clear` takes priority over `bit_valid`: a cycle with both high gives 00000.
- R9: The codeword with its last bit flipped (101000110101111) leaves the remainder 00001, and `rem_zero` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear of the remainder |
| bit_valid | input | 1 | High when `bit_in` carries a message bit |
| bit_in | input | 1 | Serial data bit, MSB first |
| remainder | output | 5 | Current division remainder |
| rem_zero | output | 1 | High when the remainder is zero |

## Verification
The division step is tested with the opening bits 1,0,1,0,0, which never set bit 4, so those steps are pure shifts. The 0 bit that follows is the first step to shift out a 1, and this checks the feedback taps. The full 15-bit codeword is then walked bit by bit against its known remainder trail. That trail reaches zero before the last bit, so a zero followed by a 0 bit is also tested. The same codeword with its last bit flipped separates an accepted codeword from a rejected one. Idle cycles with data toggling, and a clear raised together with a valid bit, test the hold behaviour and the priority of the clear.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
   localparam int unsigned CRC_WIDTH_DEF = 5;
   localparam logic [5:0]  CRC_GEN_DEF   = 6'b110101;

   typedef enum logic [0:0] {
      ZDET_FLAT = 1'b0,
      ZDET_TREE = 1'b1
   } zdet_style_e;
endpackage

// File: rtl/crc_lfsr_step.sv
module crc_lfsr_step #(
   parameter int unsigned WIDTH = 5,
   parameter logic [WIDTH:0] GEN = 6'b110101
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             din,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] TAPS = GEN[WIDTH-1:0];

   if (WIDTH < 2) begin : g_bad_width
      $error("crc_lfsr_step: WIDTH must be at least 2");
   end
   if (GEN[WIDTH] != 1'b1) begin : g_bad_gen_top
      $error("crc_lfsr_step: generator must have its top term set");
   end
   if (GEN[0] != 1'b1) begin : g_bad_gen_low
      $error("crc_lfsr_step: generator must have its constant term set");
   end

   logic fb;
   assign fb = cur[WIDTH-1];

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         if (TAPS[i]) begin : g_tap
            assign nxt[i] = din ^ fb;
         end else begin : g_notap
            assign nxt[i] = din;
         end
      end else begin : g_upper
         if (TAPS[i]) begin : g_tap
            assign nxt[i] = cur[i-1] ^ fb;
         end else begin : g_notap
            assign nxt[i] = cur[i-1];
         end
      end
   end
endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg #(
   parameter int unsigned WIDTH = 5,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             clear,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (clear) begin
         q <= INIT;
      end else if (load) begin
         q <= d;
      end
   end
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect
   import crc_chk_pkg::*;
#(
   parameter int unsigned WIDTH = 5,
   parameter zdet_style_e STYLE = ZDET_TREE
) (
   input  logic [WIDTH-1:0] val,
   output logic             is_zero
);
   localparam int unsigned PAIRS = (WIDTH + 1) / 2;

   if (STYLE == ZDET_FLAT || WIDTH < 4) begin : g_flat
      assign is_zero = ~(|val);
   end else begin : g_tree
      logic [PAIRS-1:0] pair_any;
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         if (2*p + 1 < WIDTH) begin : g_two
            assign pair_any[p] = val[2*p] | val[2*p+1];
         end else begin : g_one
            assign pair_any[p] = val[2*p];
         end
      end
      assign is_zero = ~(|pair_any);
   end
endmodule

// File: rtl/serial_crc_checker.sv
module serial_crc_checker
   import crc_chk_pkg::*;
#(
   parameter int unsigned    WIDTH = CRC_WIDTH_DEF,
   parameter logic [WIDTH:0] GEN   = CRC_GEN_DEF,
   parameter zdet_style_e    ZDET  = ZDET_TREE
) (
   input  logic             clk,
   input  logic             clear,
   input  logic             bit_valid,
   input  logic             bit_in,
   output logic [WIDTH-1:0] remainder,
   output logic             rem_zero
);
   localparam logic [WIDTH-1:0] START = '0;

   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] rem_d;

   crc_lfsr_step #(.WIDTH(WIDTH), .GEN(GEN)) step_i (
      .cur (rem_q),
      .din (bit_in),
      .nxt (rem_d)
   );

   crc_rem_reg #(.WIDTH(WIDTH), .INIT(START)) reg_i (
      .clk   (clk),
      .clear (clear),
      .load  (bit_valid),
      .d     (rem_d),
      .q     (rem_q)
   );

   crc_zero_detect #(.WIDTH(WIDTH), .STYLE(ZDET)) zdet_i (
      .val     (rem_q),
      .is_zero (rem_zero)
   );

   assign remainder = rem_q;
endmodule

// File: rtl/serial_crc_checker_sva.sv
module serial_crc_checker_sva #(
   parameter int unsigned    WIDTH = 5,
   parameter logic [WIDTH:0] GEN   = 6'b110101
) (
   input logic             clk,
   input logic             clear,
   input logic             bit_valid,
   input logic             bit_in,
   input logic [WIDTH-1:0] remainder,
   input logic             rem_zero
);
   localparam logic [WIDTH-1:0] TAPS = GEN[WIDTH-1:0];

   // R1
   clear_to_zero_chk: assert property (@(posedge clk) disable iff (clear)
      $past(clear) |-> remainder == '0);

   // R2
   shift_no_fb_chk: assert property (@(posedge clk) disable iff (clear)
      (!$past(clear) && $past(bit_valid) && !$past(remainder[WIDTH-1]))
      |-> remainder == {$past(remainder[WIDTH-2:0]), $past(bit_in)});

   // R2
   shift_fb_chk: assert property (@(posedge clk) disable iff (clear)
      (!$past(clear) && $past(bit_valid) && $past(remainder[WIDTH-1]))
      |-> (remainder ^ {$past(remainder[WIDTH-2:0]), $past(bit_in)}) == TAPS);

   // R5
   zero_stays_chk: assert property (@(posedge clk) disable iff (clear)
      (!$past(clear) && $past(bit_valid) && !$past(bit_in) && $past(remainder) == '0)
      |-> remainder == '0);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (clear)
      (!$past(clear) && !$past(bit_valid)) |-> $stable(remainder));

   // R7
   zero_flag_chk: assert property (@(posedge clk) disable iff (clear)
      rem_zero == (remainder == '0));
endmodule

bind serial_crc_checker serial_crc_checker_sva #(.WIDTH(WIDTH), .GEN(GEN)) chk_i (
   .clk       (clk),
   .clear     (clear),
   .bit_valid (bit_valid),
   .bit_in    (bit_in),
   .remainder (remainder),
   .rem_zero  (rem_zero)
);

// File: tb/serial_crc_checker_tb.sv
`timescale 1ns/1ps
module serial_crc_checker_tb_top;
   logic       clk = 1'b0;
   logic       clear = 1'b1;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic [4:0] remainder;
   logic       rem_zero;
   int         checks = 0;
   int         errors = 0;
   logic       done = 1'b0;

   always #2.5 clk = ~clk;

   serial_crc_checker dut_i (
      .clk       (clk),
      .clear     (clear),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .remainder (remainder),
      .rem_zero  (rem_zero)
   );

   // {bit, expected remainder}: codeword 101000110101110, MSB first (R3, R4)
   localparam logic [5:0] VEC [15] = '{
      {1'b1, 5'b00001}, {1'b0, 5'b00010}, {1'b1, 5'b00101}, {1'b0, 5'b01010},
      {1'b0, 5'b10100}, {1'b0, 5'b11101}, {1'b1, 5'b01110}, {1'b1, 5'b11101},
      {1'b0, 5'b01111}, {1'b1, 5'b11111}, {1'b0, 5'b01011}, {1'b1, 5'b10111},
      {1'b1, 5'b11010}, {1'b1, 5'b00000}, {1'b0, 5'b00000}
   };

   task automatic check(input string req, input logic [4:0] exp_rem);
      checks++;
      if (remainder !== exp_rem || rem_zero !== (exp_rem == 5'b0)) begin
         errors++;
         $display("FAIL %s: remainder=%b zero=%b, expected remainder=%b zero=%b",
                  req, remainder, rem_zero, exp_rem, (exp_rem == 5'b0));
      end
   endtask

   task automatic drive(input logic c, input logic v, input logic b);
      clear = c; bit_valid = v; bit_in = b;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0);
      check("R1 reset", 5'b00000);
      drive(1'b0, 1'b0, 1'b1);
      check("R6 idle after reset", 5'b00000);

      // R3 R4 R2 R7: walk the codeword
      for (int i = 0; i < 15; i++) begin
         drive(1'b0, 1'b1, VEC[i][5]);
         check((i < 6) ? "R3 step" : ((i == 14) ? "R4/R5 final" : "R2 step"), VEC[i][4:0]);
      end

      // R5: extra zero bit keeps zero
      drive(1'b0, 1'b1, 1'b0);
      check("R5 extra zero", 5'b00000);

      // R9: last bit flipped
      drive(1'b1, 1'b0, 1'b0);
      check("R1 clear", 5'b00000);
      for (int i = 0; i < 14; i++) drive(1'b0, 1'b1, VEC[i][5]);
      drive(1'b0, 1'b1, 1'b1);
      check("R9 corrupted codeword", 5'b00001);

      // R6: idle cycles with data toggling
      drive(1'b0, 1'b1, 1'b1);
      check("R2 step from 00001", 5'b00011);
      for (int i = 0; i < 4; i++) begin
         drive(1'b0, 1'b0, i[0]);
         check("R6 hold", 5'b00011);
      end

      // R8: clear wins over valid
      for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1);
      check("R2 step", 5'b11111);
      drive(1'b1, 1'b1, 1'b1);
      check("R8 clear priority", 5'b00000);
      drive(1'b0, 1'b1, 1'b1);
      check("R1 restart after clear", 5'b00001);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule